// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block sits in the feedback path of a fractional-N phase-locked loop. It runs on the divided RF clock and counts that clock down by a divide ratio that changes from one division to the next. Each completed division raises one feedback pulse for the phase detector. A third-order noise-shaping interpolator picks the next ratio. It is built from three cascaded accumulators that wrap at a programmable modulus, which does not have to be a power of two. The dither it adds moves the ratio around the programmed integer, so that the long-run mean equals the integer plus the fraction over the modulus.

Software programs the integer part, the fractional numerator and the modulus. The block takes these three values only at the boundary between divisions. It also shows the ratio of the division in progress, so the loop can be observed.

Top module: `fnd_seq`

## Requirements
- R1: While `rst` is high, `fb_pulse_o` is 0 and `n_now_o` is 0. The first rising edge with `rst` low is a division boundary, so `fb_pulse_o` is 1 in the cycle after that edge.
- R2: A division boundary happens on every edge at which the internal down-counter has reached zero. `fb_pulse_o` is high for exactly the one cycle after each boundary. The next pulse follows exactly `n_now_o` cycles later.
- R3: `n_now_o` changes only in a cycle in which `fb_pulse_o` is high. It holds the ratio of the division that this pulse starts.
- R4: The ratio loaded at a boundary is `int_i + d`, where `d = c1 + c2 - c2' + c3 - 2*c3' + c3''`. Here cK is the carry of stage K at this boundary, and a prime marks the value from one earlier stepped boundary. The ratio therefore lies in `int_i-3 .. int_i+4`.
- R5: Each stage adds its input to its residue. If the sum is at least `mod_i`, the stage subtracts `mod_i` and sets its carry. Stage 1 adds `frac_i`, and each later stage adds the new residue of the stage before it. Every residue stays below the modulus in use.
- R6: `int_i`, `frac_i` and `mod_i` are read only at a boundary. Any change between boundaries has no effect on the division in progress.
- R7: If `frac_i` is 0 at a boundary, all residues and delayed carries are cleared and the ratio is exactly `int_i`.
- R8: If `mod_i` at a boundary differs from its value at the previous boundary, all residues and delayed carries are cleared before the stage update. With zero history, the first ratio is `int_i` whenever `frac_i` is below `mod_i`.
- R9: Take a constant setting, let at least three divisions pass, and then sum the ratios of any `mod_i` consecutive divisions. The sum differs from `mod_i*int_i + frac_i` by no more than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided RF clock; every edge is one count |
| rst | input | 1 | Synchronous reset, active high |
| int_i | input | 9 | Integer part of the ratio (31 to 511) |
| frac_i | input | 12 | Fractional numerator (0 to mod_i-1) |
| mod_i | input | 12 | Accumulator modulus (2 to 4095) |
| fb_pulse_o | output | 1 | One-cycle pulse per completed division |
| n_now_o | output | 10 | Ratio of the division in progress |

## Verification
The assertions rely on legal settings: `int_i` between 31 and 511, `mod_i` at least 2, and `frac_i` below `mod_i`. Under those limits the loaded ratio can never drop below 28, so pulses are always well apart. The stimulus uses only legal triples, including both ends of the integer and modulus ranges. It changes the settings both at boundaries and in the middle of a division; a change in the middle must not leak in. It also switches the modulus and clears the fraction while the accumulators hold history.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    localparam int unsigned INT_W_DEF = 9;
    localparam int unsigned MOD_W_DEF = 12;
    localparam int unsigned CNT_W_DEF = 10;
    localparam int unsigned STAGES    = 3;
    localparam int unsigned DITHER_W  = 4;

    typedef logic signed [DITHER_W-1:0] dither_t;

    // Noise-cancelling recombination of three cascaded carries.
    function automatic dither_t shape(input logic [STAGES-1:0] c,
                                      input logic c2_z1,
                                      input logic c3_z1,
                                      input logic c3_z2);
        dither_t t;
        t = $signed(DITHER_W'(c[0]))
          + $signed(DITHER_W'(c[1])) - $signed(DITHER_W'(c2_z1))
          + $signed(DITHER_W'(c[2])) - $signed(DITHER_W'({c3_z1, 1'b0}))
          + $signed(DITHER_W'(c3_z2));
        return t;
    endfunction

endpackage

// File: rtl/fnd_accum.sv
module fnd_accum #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] res_i,
    input  logic [W-1:0] add_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] res_o,
    output logic         carry_o
);
    logic [W:0] sum;
    logic [W:0] wrapped;

    always_comb begin
        sum     = {1'b0, res_i} + {1'b0, add_i};
        wrapped = sum - {1'b0, mod_i};
        carry_o = (sum >= {1'b0, mod_i});
        res_o   = carry_o ? wrapped[W-1:0] : sum[W-1:0];
    end
endmodule

// File: rtl/fnd_mash.sv
module fnd_mash
    import fnd_pkg::*;
#(
    parameter int unsigned W = MOD_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_i,
    input  logic                flush_i,
    input  logic [W-1:0]        frac_i,
    input  logic [W-1:0]        mod_i,
    output dither_t             dither_o,
    output logic [STAGES*W-1:0] res_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] res;
        logic                     c2_z1;
        logic                     c3_z1;
        logic                     c3_z2;
    } mash_t;

    mash_t st_q, st_d, base;
    logic [W-1:0]        feed [STAGES+1];
    logic [W-1:0]        nres [STAGES];
    logic [STAGES-1:0]   carry;
    logic                frac_zero;

    assign frac_zero = (frac_i == '0);
    assign feed[0]   = frac_i;

    always_comb begin
        base = flush_i ? '0 : st_q;
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        fnd_accum #(.W(W)) u_acc (
            .res_i   (base.res[k]),
            .add_i   (feed[k]),
            .mod_i   (mod_i),
            .res_o   (nres[k]),
            .carry_o (carry[k])
        );
        assign feed[k+1] = nres[k];
    end

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (frac_zero) begin
                st_d = '0;
            end else begin
                for (int k = 0; k < STAGES; k++) begin
                    st_d.res[k] = nres[k];
                end
                st_d.c2_z1 = carry[1];
                st_d.c3_z2 = base.c3_z1;
                st_d.c3_z1 = carry[2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dither_o = frac_zero ? dither_t'(0)
                                : shape(carry, base.c2_z1, base.c3_z1, base.c3_z2);
    assign res_o    = st_q.res;
endmodule

// File: rtl/fnd_count.sv
module fnd_count #(
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] load_val_i,
    output logic          tc_o,
    output logic          pulse_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } cnt_t;

    cnt_t st_q, st_d;

    assign tc_o = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (tc_o) begin
            st_d.cnt   = load_val_i - CW'(1);
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt - CW'(1);
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/fnd_seq.sv
module fnd_seq
    import fnd_pkg::*;
#(
    parameter int unsigned INT_W = INT_W_DEF,
    parameter int unsigned MOD_W = MOD_W_DEF,
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INT_W-1:0] int_i,
    input  logic [MOD_W-1:0] frac_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic             fb_pulse_o,
    output logic [CNT_W-1:0] n_now_o
);
    localparam int unsigned WIDE_W = CNT_W + 1;

    typedef struct packed {
        logic [MOD_W-1:0] mod;
        logic [CNT_W-1:0] n;
    } top_t;

    top_t                     st_q, st_d;
    logic                     tc;
    logic                     flush;
    dither_t                  dither;
    logic [STAGES*MOD_W-1:0]  res_flat;
    logic signed [WIDE_W-1:0] n_wide;
    logic [CNT_W-1:0]         n_load;

    assign flush = (mod_i != st_q.mod);

    fnd_mash #(.W(MOD_W)) u_mash (
        .clk      (clk),
        .rst      (rst),
        .step_i   (tc),
        .flush_i  (flush),
        .frac_i   (frac_i),
        .mod_i    (mod_i),
        .dither_o (dither),
        .res_o    (res_flat)
    );

    always_comb begin
        n_wide = $signed({{(WIDE_W-INT_W){1'b0}}, int_i})
               + $signed({{(WIDE_W-DITHER_W){dither[DITHER_W-1]}}, dither});
        n_load = n_wide[CNT_W-1:0];
    end

    fnd_count #(.CW(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_val_i (n_load),
        .tc_o       (tc),
        .pulse_o    (fb_pulse_o)
    );

    always_comb begin
        st_d = st_q;
        if (tc) begin
            st_d.n   = n_load;
            st_d.mod = mod_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign n_now_o = st_q.n;
endmodule

// File: rtl/fnd_seq_chk.sv
module fnd_seq_chk
    import fnd_pkg::*;
#(
    parameter int unsigned INT_W = INT_W_DEF,
    parameter int unsigned MOD_W = MOD_W_DEF,
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input logic                    clk,
    input logic                    rst,
    input logic [INT_W-1:0]        int_i,
    input logic [MOD_W-1:0]        frac_i,
    input logic                    fb_pulse_o,
    input logic [CNT_W-1:0]        n_now_o,
    input logic [STAGES*MOD_W-1:0] res_flat,
    input logic [MOD_W-1:0]        mod_used
);
    logic [15:0]      since_q;
    logic [CNT_W-1:0] hold_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            hold_q  <= '0;
            seen_q  <= 1'b0;
        end else if (fb_pulse_o) begin
            since_q <= 16'd1;
            hold_q  <= n_now_o;
            seen_q  <= 1'b1;
        end else begin
            since_q <= since_q + 16'd1;
        end
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fb_pulse_o |=> !fb_pulse_o);

    a_r2_pulse_spacing: assert property (@(posedge clk) disable iff (rst)
        (fb_pulse_o && seen_q) |-> (since_q == 16'(hold_q)));

    a_r3_hold_ratio: assert property (@(posedge clk) disable iff (rst)
        !fb_pulse_o |-> $stable(n_now_o));

    a_r4_ratio_range: assert property (@(posedge clk) disable iff (rst)
        fb_pulse_o |-> (int'(n_now_o) >= int'($past(int_i)) - 3 &&
                        int'(n_now_o) <= int'($past(int_i)) + 4));

    a_r7_plain_integer: assert property (@(posedge clk) disable iff (rst)
        (fb_pulse_o && $past(frac_i) == '0) |-> (int'(n_now_o) == int'($past(int_i))));

    a_r5_residue_below_mod: assert property (@(posedge clk) disable iff (rst)
        (mod_used != '0) |-> (res_flat[MOD_W-1:0] < mod_used &&
                              res_flat[2*MOD_W-1:MOD_W] < mod_used &&
                              res_flat[3*MOD_W-1:2*MOD_W] < mod_used));
endmodule

bind fnd_seq fnd_seq_chk #(.INT_W(INT_W), .MOD_W(MOD_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .int_i      (int_i),
    .frac_i     (frac_i),
    .fb_pulse_o (fb_pulse_o),
    .n_now_o    (n_now_o),
    .res_flat   (res_flat),
    .mod_used   (st_q.mod)
);

// File: tb/test_fnd_seq.sv
module test_fnd_seq;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] int_r = 9'd100;
    logic [11:0] frac_r = 12'd0;
    logic [11:0] mod_r  = 12'd7;
    logic       fb_pulse;
    logic [9:0] n_now;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_res [3];
    int m_c2z1, m_c3z1, m_c3z2, m_modprev, m_cnt, m_n, m_pulse;
    int nq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fnd_seq i_fnd_seq (
        .clk        (clk),
        .rst        (rst),
        .int_i      (int_r),
        .frac_i     (frac_r),
        .mod_i      (mod_r),
        .fb_pulse_o (fb_pulse),
        .n_now_o    (n_now)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_step();
        int a, s, c [3], y;
        if (rst) begin
            foreach (m_res[k]) m_res[k] = 0;
            m_c2z1 = 0; m_c3z1 = 0; m_c3z2 = 0; m_modprev = 0;
            m_cnt = 0; m_n = 0; m_pulse = 0;
        end else if (m_cnt == 0) begin
            if (frac_r == 0) begin
                foreach (m_res[k]) m_res[k] = 0;
                m_c2z1 = 0; m_c3z1 = 0; m_c3z2 = 0;
                m_n = int_r;
            end else begin
                if (int'(mod_r) != m_modprev) begin
                    foreach (m_res[k]) m_res[k] = 0;
                    m_c2z1 = 0; m_c3z1 = 0; m_c3z2 = 0;
                end
                a = frac_r;
                for (int k = 0; k < 3; k++) begin
                    s = m_res[k] + a;
                    c[k] = (s >= mod_r) ? 1 : 0;
                    if (c[k] == 1) s = s - mod_r;
                    m_res[k] = s;
                    a = s;
                end
                y = c[0] + c[1] - m_c2z1 + c[2] - 2 * m_c3z1 + m_c3z2;
                m_c2z1 = c[1];
                m_c3z2 = m_c3z1;
                m_c3z1 = c[2];
                m_n = int_r + y;
            end
            m_modprev = mod_r;
            m_cnt = m_n - 1;
            m_pulse = 1;
        end else begin
            m_cnt--;
            m_pulse = 0;
        end
    endtask

    // inputs already set for the next edge; advance model, then sample at negedge
    task automatic tick();
        model_step();
        @(negedge clk);
        check(fb_pulse === m_pulse[0] && n_now === 10'(m_n),
              "R2/R3/R4/R5/R6/R8 per-cycle model", int'(n_now) + 1000 * int'(fb_pulse),
              m_n + 1000 * m_pulse);
        if (fb_pulse === 1'b1) nq.push_back(int'(n_now));
    endtask

    task automatic run_cfg(input int i, input int f, input int m, input int nd);
        int sum, lo;
        int_r = 9'(i); frac_r = 12'(f); mod_r = 12'(m);
        nq.delete();
        while (nq.size() < nd) tick();
        foreach (nq[k]) begin
            check(nq[k] >= i - 3 && nq[k] <= i + 4, "R4 ratio range", nq[k], i);
            if (f == 0) check(nq[k] == i, "R7 zero fraction gives integer", nq[k], i);
        end
        if (nd >= m + 3) begin
            sum = 0;
            lo = nq.size() - m;
            for (int k = lo; k < nq.size(); k++) sum += nq[k];
            check(sum >= m * i + f - 3 && sum <= m * i + f + 3,
                  "R9 window mean", sum, m * i + f);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual cycles %0d expected fewer", WD_CYCLES);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) tick();
        check(fb_pulse === 1'b0, "R1 pulse low in reset", int'(fb_pulse), 0);
        check(n_now === 10'd0, "R1 ratio zero in reset", int'(n_now), 0);
        rst = 1'b0;
        tick();
        check(fb_pulse === 1'b1, "R1 first edge after reset is a boundary", int'(fb_pulse), 1);

        run_cfg(100, 0, 7, 10);
        run_cfg(40, 3, 5, 12);
        run_cfg(31, 7, 13, 20);
        run_cfg(60, 37, 100, 106);
        run_cfg(511, 2, 3, 10);
        run_cfg(511, 4094, 4095, 12);
        run_cfg(31, 4094, 4095, 12);
        run_cfg(34, 1, 2, 12);

        // R8: modulus change clears history
        run_cfg(45, 5, 9, 14);
        run_cfg(45, 5, 11, 16);
        check(nq[0] == 45, "R8 first ratio after modulus change", nq[0], 45);

        // R7: fraction dropped to zero with history present
        run_cfg(80, 6, 11, 8);
        run_cfg(80, 0, 11, 8);
        check(nq[0] == 80, "R7 first ratio after fraction cleared", nq[0], 80);

        // R6: mid-division changes are ignored
        run_cfg(70, 9, 17, 22);
        while (m_cnt <= 10) tick();
        int_r = 9'd400; frac_r = 12'd0; mod_r = 12'd3;
        repeat (3) tick();
        int_r = 9'd70; frac_r = 12'd9; mod_r = 12'd17;
        nq.delete();
        while (nq.size() < 3) tick();
        check(nq[0] >= 67 && nq[0] <= 74, "R6 glitch between boundaries ignored", nq[0], 70);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule